// File: doc/BRIEF.md
# Predicate-Carry Add/Subtract and Byte-Minimum Unit

This block is a 64-bit integer slice that treats an 8-bit predicate as an extra operand and an extra result. For the two arithmetic operations, bit 0 of the incoming predicate is the carry in. The carry out of the top bit is then spread over all eight predicate bits. The third operation finds the unsigned minimum of each of the eight byte lanes of two operands. For that operation, the returned predicate holds one comparison flag per lane.

Each operation is presented together with `in_valid`. The result and the new predicate are registered, and they appear with `out_valid` one clock later. Back-to-back operations are accepted every cycle. Between accepted operations, the registered outputs hold their last values.

Top module: `pc_alu_slice`

## Requirements
- R1: With `op` = 2'b00 (add-carry), `result` = `opa` + `opb` + `pred_in[0]`, modulo 2^64.
- R2: Predicate bits 7..1 have no effect on `result` or `pred_out` for add-carry and subtract-carry.
- R3: With `op` = 2'b01 (subtract-carry), `result` = `opa` + ~`opb` + `pred_in[0]`, modulo 2^64. A `pred_in[0]` of 1 therefore means that no borrow comes in.
- R4: For add-carry and subtract-carry, `pred_out` is 8'hFF when the sum carries out of bit 63 and 8'h00 otherwise.
- R5: With `op` = 2'b10 (byte-min), result byte i (bits 8i+7..8i) is the unsigned minimum of byte i of `opa` and byte i of `opb`, for i = 0..7.
- R6: For byte-min, `pred_out[i]` is 1 exactly when byte i of `opb` is greater (unsigned) than byte i of `opa`.
- R7: For byte-min, a lane whose two bytes are equal gives `pred_out[i]` = 0.
- R8: With `op` = 2'b11, `result` is zero and `pred_out` equals `pred_in`.
- R9: While reset is held, `out_valid` is 0, `result` is zero and `pred_out` is zero.
- R10: An operation accepted with `in_valid` on one rising edge appears on the outputs with `out_valid` = 1 after that edge. Cycles without `in_valid` drive `out_valid` to 0 and leave `result` and `pred_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Accept an operation on this edge |
| op | input | 2 | 00 add-carry, 01 subtract-carry, 10 byte-min, 11 zero/pass predicate |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| pred_in | input | 8 | Incoming predicate |
| out_valid | output | 1 | Outputs hold the result of the operation accepted on the previous edge |
| result | output | 64 | Registered 64-bit result |
| pred_out | output | 8 | Registered new predicate |

## Verification
The bench goes after the carry edges. It drives an all-ones operand plus a carry in, which wraps to zero. A design that dropped the carry would return all ones, and one that did not replicate the carry would show 8'h01 instead of 8'hFF. For subtraction with equal operands and no incoming carry, the expected result is all ones with a clear predicate. A design that negated the second operand as a two's complement would instead return zero with 8'hFF. Cases with the upper predicate bits set and bit 0 clear catch a design that used the whole predicate as the carry. For byte-min, the bench uses mixed lanes, equal lanes and fully equal operands. These catch swapped comparison operands, a `>=` compare in place of `>`, or a lane slice taken at the wrong offset. The spare opcode is checked to return zero and to pass the predicate through untouched.

// File: rtl/pc_alu_pkg.sv
package pc_alu_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = DATA_W / LANE_W;

  typedef enum logic [1:0] {
    OP_ADDC = 2'b00,
    OP_SUBC = 2'b01,
    OP_BMIN = 2'b10,
    OP_ZERO = 2'b11
  } pc_op_e;
endpackage

// File: rtl/pc_carry_adder.sv
module pc_carry_adder #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
  end
endmodule

// File: rtl/pc_byte_min.sv
module pc_byte_min #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 8,
  localparam int unsigned W     = LANE_W * LANES
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     min_out,
  output logic [LANES-1:0] b_gt_a
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] la;
    logic [LANE_W-1:0] lb;
    logic              gt;

    always_comb begin
      la = a[i*LANE_W +: LANE_W];
      lb = b[i*LANE_W +: LANE_W];
      gt = (lb > la);
      min_out[i*LANE_W +: LANE_W] = gt ? la : lb;
      b_gt_a[i] = gt;
    end

    // R7: equal lanes never raise the flag
    always_comb begin
      if (la == lb) begin
        p_equal_clear_r7: assert (!b_gt_a[i]);
      end
    end
  end
endmodule

// File: rtl/pc_alu_slice.sv
module pc_alu_slice
  import pc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [LANES-1:0]  pred_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [LANES-1:0]  pred_out
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pc_op_e op_e;
  assign op_e = pc_op_e'(op);

  logic [DATA_W-1:0] sum;
  logic              cout;
  logic [DATA_W-1:0] bmin;
  logic [LANES-1:0]  bmask;

  pc_carry_adder #(.W(DATA_W)) u_add (
    .a        (opa),
    .b        (opb),
    .invert_b (op_e == OP_SUBC),
    .cin      (pred_in[0]),
    .sum      (sum),
    .cout     (cout)
  );

  pc_byte_min #(.LANE_W(LANE_W), .LANES(LANES)) u_min (
    .a       (opa),
    .b       (opb),
    .min_out (bmin),
    .b_gt_a  (bmask)
  );

  // next-state selection
  logic [DATA_W-1:0] res_d;
  logic [LANES-1:0]  pred_d;
  always_comb begin
    unique case (op_e)
      OP_ADDC, OP_SUBC: begin
        res_d  = sum;
        pred_d = {LANES{cout}};
      end
      OP_BMIN: begin
        res_d  = bmin;
        pred_d = bmask;
      end
      default: begin
        res_d  = '0;
        pred_d = pred_in;
      end
    endcase
  end

  // registers
  logic [DATA_W-1:0] res_q;
  logic [LANES-1:0]  pred_q;
  logic              vld_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      pred_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q  <= res_d;
        pred_q <= pred_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign pred_out  = pred_q;

  // R10: accepted op shows one edge later
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  // R10: idle cycles keep the outputs
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(pred_out)));
  // R4: arithmetic predicate is all zeros or all ones
  p_carry_fill_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (op == 2'b00 || op == 2'b01)) |=>
      (pred_out == '0 || pred_out == '1));
  // R8: spare code gives zero and passes the predicate
  p_spare_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == 2'b11) |=>
      (result == '0 && pred_out == $past(pred_in)));
  // R6: a lane flag set means the result byte came from opa
  p_min_flag_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == 2'b10 && bmask[0]) |=>
      (result[LANE_W-1:0] == $past(opa[LANE_W-1:0])));
endmodule

// File: tb/pc_alu_slice_tb.sv
module pc_alu_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic [63:0] opa, opb;
  logic [7:0]  pred_in;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  pred_out;

  always #5 clk = ~clk;

  pc_alu_slice dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .pred_in(pred_in),
    .out_valid(out_valid), .result(result), .pred_out(pred_out)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [63:0] exp_res_q[$];
  logic [7:0]  exp_pred_q[$];
  string       exp_tag_q[$];

  function automatic logic [71:0] model(input logic [1:0] o, input logic [63:0] a,
                                        input logic [63:0] b, input logic [7:0] p);
    logic [64:0] w;
    logic [63:0] r;
    logic [7:0]  q;
    r = '0; q = '0;
    case (o)
      2'b00: begin w = {1'b0, a} + {1'b0, b} + 65'(p[0]); r = w[63:0]; q = {8{w[64]}}; end
      2'b01: begin w = {1'b0, a} + {1'b0, ~b} + 65'(p[0]); r = w[63:0]; q = {8{w[64]}}; end
      2'b10: begin
        for (int i = 0; i < 8; i++) begin
          if (b[8*i +: 8] > a[8*i +: 8]) begin
            r[8*i +: 8] = a[8*i +: 8]; q[i] = 1'b1;
          end else begin
            r[8*i +: 8] = b[8*i +: 8]; q[i] = 1'b0;
          end
        end
      end
      default: begin r = '0; q = p; end
    endcase
    return {r, q};
  endfunction

  task automatic drive(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] p, input string tag);
    logic [71:0] e;
    e = model(o, a, b, p);
    exp_res_q.push_back(e[71:8]);
    exp_pred_q.push_back(e[7:0]);
    exp_tag_q.push_back(tag);
    in_valid = 1'b1; op = o; opa = a; opb = b; pred_in = p;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [71:0] act,
                       input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_res_q.size() == 0) begin
        check(1'b0, "R10 unexpected out_valid", {result, pred_out}, '0);
      end else begin
        logic [63:0] er;
        logic [7:0]  ep;
        string       t;
        er = exp_res_q.pop_front();
        ep = exp_pred_q.pop_front();
        t  = exp_tag_q.pop_front();
        check(result == er && pred_out == ep, t, {result, pred_out}, {er, ep});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_r;
    logic [7:0]  held_p;
    rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = '0; opb = '0; pred_in = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && result == '0 && pred_out == '0, "R9 reset state",
          {result, pred_out}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive(2'b00, 64'd1, 64'd2, 8'h00, "R1 add small");
    drive(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'h01, "R1 R4 add wrap carry");
    drive(2'b00, 64'd5, 64'd6, 8'hFE, "R2 add upper pred ignored");
    drive(2'b00, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h00, "R4 add carry out");
    drive(2'b01, 64'd10, 64'd3, 8'h01, "R3 sub no borrow");
    drive(2'b01, 64'd3, 64'd10, 8'h01, "R3 R4 sub underflow");
    drive(2'b01, 64'd5, 64'd5, 8'h00, "R3 sub equal borrow in");
    drive(2'b01, 64'd9, 64'd4, 8'hFE, "R2 sub upper pred ignored");
    drive(2'b10, 64'h00FF_7F80_1234_0102, 64'h0100_807F_1234_0201, 8'h00, "R5 R6 R7 min mixed");
    drive(2'b10, 64'hA5A5_A5A5_A5A5_A5A5, 64'hA5A5_A5A5_A5A5_A5A5, 8'hFF, "R7 min all equal");
    drive(2'b10, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R6 min b greater all lanes");
    drive(2'b11, 64'h1234, 64'h5678, 8'h5A, "R8 spare code");
    repeat (2) @(negedge clk);

    held_r = result; held_p = pred_out;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && result == held_r && pred_out == held_p, "R10 idle hold",
          {result, pred_out}, {held_r, held_p});
    check(exp_res_q.size() == 0, "R10 all results seen", 72'(exp_res_q.size()), '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule